// File: doc/BRIEF.md
# Repeated String Transfer Engine

This block is a memory-to-memory copy sequencer. One pulse on `start` captures the operating mode and the starting values. The mode is element size, pointer direction and repeat. The starting values are two segment bases, two pointer offsets and an element count. The engine then copies elements one at a time. Each element is fetched through the source pointer, relative to the data segment, and stored through the destination pointer, relative to the extra segment. After each element both pointers move by the element size, upward or downward as the direction input selects.

With repeat set, the count goes down by one after every element and the copy ends when it reaches zero. A starting count of zero finishes at once without touching memory. With repeat clear, exactly one element is copied and the count is left alone. Memory is reached through a read port and a write port, each with a valid/ready handshake. A one-cycle `done` pulse marks the end. The final pointers and the remaining count are on the outputs from then until the next start.

Top module: `strmove_engine`

## Requirements
- R1: After reset the engine is idle: `busy`, `done`, `rd_valid` and `wr_valid` are low and `src_ptr`, `dst_ptr` and `count_left` are zero.
- R2: A read is issued at address `data_seg`*16 + source pointer and the matching write at `extra_seg`*16 + destination pointer, both 20 bits wide (bits above 19 dropped).
- R3: Each element is read once and then written once with the data read. With `word_mode`=1 all 16 bits are copied and `rd_word`/`wr_word` are 1. With `word_mode`=0 only `rd_data[7:0]` is copied, `wr_data[15:8]` is 0, and `rd_word`/`wr_word` are 0.
- R4: After each element both pointers change by 1 (byte) or 2 (word). They increase when `dir_down`=0 and decrease when `dir_down`=1, modulo 2^16.
- R5: With `repeat_en`=1 the count drops by one after each element, and the copy continues while it is nonzero. N elements are moved for a start count N, and `count_left` ends at 0.
- R6: With `repeat_en`=0 exactly one element is moved and `count_left` keeps the value of `count_in` at start.
- R7: With `repeat_en`=1 and `count_in`=0, no read or write is issued, and `done` is high in the cycle right after the start edge.
- R8: A raised `rd_valid` or `wr_valid` stays high with a stable address (and stable write data) until its ready is seen, whatever the number of wait cycles.
- R9: `done` is high for exactly one cycle. While it is high, `src_ptr`, `dst_ptr` and `count_left` show the final values, and they keep them afterwards.
- R10: A `start` pulse while `busy` is high has no effect on the running copy or its results.
- R11: `rd_valid` and `wr_valid` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a copy (taken only when idle) |
| word_mode | input | 1 | 1: 16-bit elements, 0: 8-bit elements |
| dir_down | input | 1 | 1: pointers decrease, 0: pointers increase |
| repeat_en | input | 1 | 1: repeat under the count, 0: one element |
| data_seg | input | 16 | Segment base for the source |
| src_off | input | 16 | Initial source pointer |
| extra_seg | input | 16 | Segment base for the destination |
| dst_off | input | 16 | Initial destination pointer |
| count_in | input | 16 | Initial element count |
| busy | output | 1 | Copy in progress (including the done cycle) |
| done | output | 1 | One-cycle completion pulse |
| src_ptr | output | 16 | Current source pointer |
| dst_ptr | output | 16 | Current destination pointer |
| count_left | output | 16 | Current count |
| rd_valid | output | 1 | Read request |
| rd_ready | input | 1 | Read accepted, `rd_data` valid |
| rd_addr | output | 20 | Read address |
| rd_word | output | 1 | Read is 16 bits wide |
| rd_data | input | 16 | Read data |
| wr_valid | output | 1 | Write request |
| wr_ready | input | 1 | Write accepted |
| wr_addr | output | 20 | Write address |
| wr_word | output | 1 | Write is 16 bits wide |
| wr_data | output | 16 | Write data |

## Verification
A wrong sequencer state shows up at the memory ports within one handshake. It appears as a read and a write raised together, a request that drops before ready, or an extra or missing element in the write stream. A wrong pointer or stride gives a wrong address on the next read or write, so the first bad element is caught at its own transfer. A wrong count does not show as an address. It shows only as the wrong number of writes before `done`, or a nonzero `count_left` at `done`. The zero-count start and the start while busy are therefore checked through the write log and the final register values.

// File: rtl/smv_pkg.sv
package smv_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_READ,
      ST_WRITE,
      ST_UPDATE,
      ST_DONE
   } smv_state_e;

   typedef struct packed {
      logic word;
      logic dir_down;
      logic rep;
   } smv_cfg_t;

   localparam int unsigned SMV_ROLES = 2;
   localparam int unsigned SMV_SRC   = 0;
   localparam int unsigned SMV_DST   = 1;

endpackage

// File: rtl/smv_ptr_step.sv
module smv_ptr_step #(
   parameter int OFF_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [OFF_W-1:0] init,
   input  logic             step_en,
   input  logic             dir_down,
   input  logic             word,
   output logic [OFF_W-1:0] ptr
);

   logic [OFF_W-1:0] stride;

   always_comb stride = word ? OFF_W'(2) : OFF_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ptr <= '0;
      else if (load)
         ptr <= init;
      else if (step_en)
         ptr <= dir_down ? (ptr - stride) : (ptr + stride);
   end

endmodule

// File: rtl/smv_addr_gen.sv
module smv_addr_gen #(
   parameter int OFF_W     = 16,
   parameter int SEG_SHIFT = 4,
   localparam int ADDR_W   = OFF_W + SEG_SHIFT
) (
   input  logic [OFF_W-1:0]  seg,
   input  logic [OFF_W-1:0]  off,
   output logic [ADDR_W-1:0] addr
);

   logic [ADDR_W-1:0] base;
   logic [ADDR_W-1:0] disp;

   always_comb begin
      base = {seg, {SEG_SHIFT{1'b0}}};
      disp = {{SEG_SHIFT{1'b0}}, off};
      addr = base + disp;
   end

endmodule

// File: rtl/smv_count.sv
module smv_count #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] init,
   input  logic             dec,
   output logic [CNT_W-1:0] cnt,
   output logic             last
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= init;
      else if (dec)
         cnt <= cnt - CNT_W'(1);
   end

   always_comb last = (cnt == CNT_W'(1));

endmodule

// File: rtl/smv_ctrl.sv
module smv_ctrl
   import smv_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       start_empty,
   input  logic       rep,
   input  logic       cnt_last,
   input  logic       rd_ready,
   input  logic       wr_ready,
   output smv_state_e state,
   output logic       load,
   output logic       capture,
   output logic       step,
   output logic       dec,
   output logic       rd_valid,
   output logic       wr_valid,
   output logic       busy,
   output logic       done
);

   smv_state_e nxt;

   always_comb begin
      nxt     = state;
      load    = 1'b0;
      capture = 1'b0;
      step    = 1'b0;
      dec     = 1'b0;
      unique case (state)
         ST_IDLE: begin
            if (start) begin
               load = 1'b1;
               nxt  = start_empty ? ST_DONE : ST_READ;
            end
         end
         ST_READ: begin
            if (rd_ready) begin
               capture = 1'b1;
               nxt     = ST_WRITE;
            end
         end
         ST_WRITE: begin
            if (wr_ready) nxt = ST_UPDATE;
         end
         ST_UPDATE: begin
            step = 1'b1;
            if (rep) begin
               dec = 1'b1;
               nxt = cnt_last ? ST_DONE : ST_READ;
            end else begin
               nxt = ST_DONE;
            end
         end
         ST_DONE: nxt = ST_IDLE;
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= nxt;
   end

   always_comb begin
      rd_valid = (state == ST_READ);
      wr_valid = (state == ST_WRITE);
      busy     = (state != ST_IDLE);
      done     = (state == ST_DONE);
   end

   // R11
   rw_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_valid && wr_valid));

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

endmodule

// File: rtl/strmove_engine.sv
module strmove_engine
   import smv_pkg::*;
#(
   parameter int OFF_W     = 16,
   parameter int SEG_SHIFT = 4,
   parameter int CNT_W     = 16,
   parameter int DATA_W    = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   input  logic                     word_mode,
   input  logic                     dir_down,
   input  logic                     repeat_en,
   input  logic [OFF_W-1:0]         data_seg,
   input  logic [OFF_W-1:0]         src_off,
   input  logic [OFF_W-1:0]         extra_seg,
   input  logic [OFF_W-1:0]         dst_off,
   input  logic [CNT_W-1:0]         count_in,
   output logic                     busy,
   output logic                     done,
   output logic [OFF_W-1:0]         src_ptr,
   output logic [OFF_W-1:0]         dst_ptr,
   output logic [CNT_W-1:0]         count_left,
   output logic                     rd_valid,
   input  logic                     rd_ready,
   output logic [OFF_W+SEG_SHIFT-1:0] rd_addr,
   output logic                     rd_word,
   input  logic [DATA_W-1:0]        rd_data,
   output logic                     wr_valid,
   input  logic                     wr_ready,
   output logic [OFF_W+SEG_SHIFT-1:0] wr_addr,
   output logic                     wr_word,
   output logic [DATA_W-1:0]        wr_data
);

   localparam int ADDR_W = OFF_W + SEG_SHIFT;
   localparam int BYTE_W = DATA_W / 2;

   if (DATA_W != 16) begin : g_bad_data
      $error("strmove_engine: DATA_W must be 16");
   end
   if (OFF_W < 2) begin : g_bad_off
      $error("strmove_engine: OFF_W too small for a word stride");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("strmove_engine: CNT_W must be positive");
   end

   smv_state_e             state;
   smv_cfg_t               cfg_q;
   logic                   load, capture, step, dec, cnt_last, start_empty;
   logic [OFF_W-1:0]       seg_q  [SMV_ROLES];
   logic [OFF_W-1:0]       ptr_in [SMV_ROLES];
   logic [OFF_W-1:0]       seg_in [SMV_ROLES];
   logic [OFF_W-1:0]       ptr    [SMV_ROLES];
   logic [ADDR_W-1:0]      addr   [SMV_ROLES];
   logic [DATA_W-1:0]      buf_q;

   always_comb begin
      ptr_in[SMV_SRC] = src_off;
      ptr_in[SMV_DST] = dst_off;
      seg_in[SMV_SRC] = data_seg;
      seg_in[SMV_DST] = extra_seg;
      start_empty     = repeat_en && (count_in == '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cfg_q <= '0;
      else if (load)
         cfg_q <= '{word: word_mode, dir_down: dir_down, rep: repeat_en};
   end

   for (genvar r = 0; r < SMV_ROLES; r++) begin : g_role
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    seg_q[r] <= '0;
         else if (load) seg_q[r] <= seg_in[r];
      end

      smv_ptr_step #(.OFF_W(OFF_W)) i_ptr (
         .clk      (clk),
         .rst_n    (rst_n),
         .load     (load),
         .init     (ptr_in[r]),
         .step_en  (step),
         .dir_down (cfg_q.dir_down),
         .word     (cfg_q.word),
         .ptr      (ptr[r])
      );

      smv_addr_gen #(.OFF_W(OFF_W), .SEG_SHIFT(SEG_SHIFT)) i_addr (
         .seg  (seg_q[r]),
         .off  (ptr[r]),
         .addr (addr[r])
      );
   end

   smv_count #(.CNT_W(CNT_W)) i_count (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load),
      .init  (count_in),
      .dec   (dec),
      .cnt   (count_left),
      .last  (cnt_last)
   );

   smv_ctrl i_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .start_empty (start_empty),
      .rep         (cfg_q.rep),
      .cnt_last    (cnt_last),
      .rd_ready    (rd_ready),
      .wr_ready    (wr_ready),
      .state       (state),
      .load        (load),
      .capture     (capture),
      .step        (step),
      .dec         (dec),
      .rd_valid    (rd_valid),
      .wr_valid    (wr_valid),
      .busy        (busy),
      .done        (done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         buf_q <= '0;
      else if (capture)
         buf_q <= cfg_q.word ? rd_data : {{(DATA_W-BYTE_W){1'b0}}, rd_data[BYTE_W-1:0]};
   end

   always_comb begin
      src_ptr = ptr[SMV_SRC];
      dst_ptr = ptr[SMV_DST];
      rd_addr = addr[SMV_SRC];
      wr_addr = addr[SMV_DST];
      rd_word = cfg_q.word;
      wr_word = cfg_q.word;
      wr_data = buf_q;
   end

   // R8
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));

   // R8
   wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

   // R3
   byte_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid && !wr_word |-> wr_data[DATA_W-1:BYTE_W] == '0);

   // R5
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid && wr_ready && cfg_q.rep |=> ##1 (count_left == $past(count_left, 2) - CNT_W'(1)));

   // R7
   empty_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && start && repeat_en && count_in == '0 |=> done && !rd_valid && !wr_valid);

   // R6
   single_keeps_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !done && !cfg_q.rep |=> $stable(count_left));

endmodule

// File: tb/test_strmove_engine.sv
module test_strmove_engine;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0, word_mode = 1'b0, dir_down = 1'b0, repeat_en = 1'b0;
   logic [15:0] data_seg = '0, src_off = '0, extra_seg = '0, dst_off = '0, count_in = '0;
   logic        busy, done, rd_valid, wr_valid, rd_word, wr_word;
   logic        rd_ready = 1'b0, wr_ready = 1'b0;
   logic [15:0] src_ptr, dst_ptr, count_left, wr_data;
   logic [15:0] rd_data = '0;
   logic [19:0] rd_addr, wr_addr;

   int errors = 0;
   int checks = 0;
   int lat = 0;
   int rd_wait = 0, wr_wait = 0;
   int rd_n = 0, wr_n = 0;
   logic [19:0] log_a [0:63];
   logic [15:0] log_d [0:63];
   logic        log_w [0:63];

   always #(CLK_PERIOD/2) clk = ~clk;

   strmove_engine i_strmove_engine (
      .clk(clk), .rst_n(rst_n), .start(start), .word_mode(word_mode),
      .dir_down(dir_down), .repeat_en(repeat_en), .data_seg(data_seg),
      .src_off(src_off), .extra_seg(extra_seg), .dst_off(dst_off),
      .count_in(count_in), .busy(busy), .done(done), .src_ptr(src_ptr),
      .dst_ptr(dst_ptr), .count_left(count_left), .rd_valid(rd_valid),
      .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_word(rd_word),
      .rd_data(rd_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
      .wr_addr(wr_addr), .wr_word(wr_word), .wr_data(wr_data)
   );

   function automatic logic [7:0] mem_byte(input logic [19:0] a);
      return a[7:0] ^ a[15:8] ^ {4'h0, a[19:16]} ^ 8'hA5;
   endfunction

   // Memory model: decides ready at the falling edge; handshake completes on the next rising edge.
   always @(negedge clk) begin
      if (rd_valid) begin
         rd_data = rd_word ? {mem_byte(rd_addr + 20'd1), mem_byte(rd_addr)}
                           : {8'hEE, mem_byte(rd_addr)};
         if (rd_wait >= lat) begin
            rd_ready = 1'b1;
            rd_wait  = 0;
            rd_n++;
         end else begin
            rd_ready = 1'b0;
            rd_wait++;
         end
      end else begin
         rd_ready = 1'b0;
      end
      if (wr_valid) begin
         if (wr_wait >= lat) begin
            wr_ready = 1'b1;
            wr_wait  = 0;
            if (wr_n < 64) begin
               log_a[wr_n] = wr_addr;
               log_d[wr_n] = wr_data;
               log_w[wr_n] = wr_word;
            end
            wr_n++;
         end else begin
            wr_ready = 1'b0;
            wr_wait++;
         end
      end else begin
         wr_ready = 1'b0;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic check_reset();
      // R1
      chk(!busy && !done, "R1", "busy/done after reset", {busy, done}, 0);
      chk(!rd_valid && !wr_valid, "R1", "valid after reset", {rd_valid, wr_valid}, 0);
      chk(src_ptr == 0 && dst_ptr == 0 && count_left == 0, "R1", "regs after reset",
          {src_ptr, dst_ptr, count_left}, 0);
   endtask

   task automatic run_xfer(input bit w, input bit dn, input bit rp,
                           input logic [15:0] ds, input logic [15:0] si,
                           input logic [15:0] es, input logic [15:0] di,
                           input logic [15:0] cnt, input int latency, input bit poke);
      int n, t;
      logic [15:0] s, d, stride;
      logic [19:0] sa, da;
      logic [15:0] ed;
      lat = latency;
      rd_n = 0;
      wr_n = 0;
      word_mode = w; dir_down = dn; repeat_en = rp;
      data_seg = ds; src_off = si; extra_seg = es; dst_off = di; count_in = cnt;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      src_off = 16'hDEAD; dst_off = 16'hBEEF; count_in = 16'h0007;
      t = 0;
      while (!done && t < 4000) begin
         if (poke && t == 3) begin
            // R10: start while busy, with other settings
            start = 1'b1; repeat_en = 1'b0; word_mode = ~w; dir_down = ~dn;
            data_seg = 16'h0F0F; src_off = 16'h1234;
         end else begin
            start = 1'b0;
         end
         @(negedge clk);
         t++;
      end
      start = 1'b0;
      chk(done, "R9", "done reached", done, 1);
      n = rp ? int'(cnt) : 1;
      chk(wr_n == n, rp ? "R5" : "R6", "element count", wr_n, n);
      chk(rd_n == n, "R3", "read count", rd_n, n);
      s = si; d = di;
      stride = w ? 16'd2 : 16'd1;
      for (int i = 0; i < n && i < 64; i++) begin
         sa = {ds, 4'h0} + {4'h0, s};
         da = {es, 4'h0} + {4'h0, d};
         ed = w ? {mem_byte(sa + 20'd1), mem_byte(sa)} : {8'h00, mem_byte(sa)};
         chk(log_a[i] == da, "R2", "write address", log_a[i], da);
         chk(log_d[i] == ed, "R3", "write data", log_d[i], ed);
         chk(log_w[i] == w, "R3", "write size flag", log_w[i], w);
         s = dn ? s - stride : s + stride;
         d = dn ? d - stride : d + stride;
      end
      chk(src_ptr == s, "R4", "final source pointer", src_ptr, s);
      chk(dst_ptr == d, "R4", "final destination pointer", dst_ptr, d);
      chk(count_left == (rp ? 16'd0 : cnt), rp ? "R5" : "R6", "final count",
          count_left, rp ? 0 : cnt);
      @(negedge clk);
      chk(!done, "R9", "done one cycle", done, 0);
      chk(src_ptr == s && dst_ptr == d, "R9", "pointers held after done",
          {src_ptr, dst_ptr}, {s, d});
      chk(!busy, "R9", "idle after done", busy, 0);
   endtask

   task automatic test_empty();
      // R7
      rd_n = 0; wr_n = 0; lat = 0;
      word_mode = 1'b1; dir_down = 1'b0; repeat_en = 1'b1;
      src_off = 16'h0100; dst_off = 16'h0200; count_in = 16'h0000;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(done, "R7", "done right after start", done, 1);
      chk(!rd_valid && !wr_valid, "R7", "no request", {rd_valid, wr_valid}, 0);
      chk(src_ptr == 16'h0100 && dst_ptr == 16'h0200, "R7", "pointers unmoved",
          {src_ptr, dst_ptr}, {16'h0100, 16'h0200});
      @(negedge clk);
      chk(!done, "R7", "done drops", done, 0);
      repeat (3) @(negedge clk);
      chk(rd_n == 0 && wr_n == 0, "R7", "no memory access", rd_n + wr_n, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 2 + 2);
      check_reset();
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R3 R4 R5 word, upward, no waits
      run_xfer(1'b1, 1'b0, 1'b1, 16'h1000, 16'h0010, 16'h2000, 16'h0040, 16'd4, 0, 1'b0);
      // R3 R4 R8 byte, downward, wait states
      run_xfer(1'b0, 1'b1, 1'b1, 16'h0300, 16'h0055, 16'h0700, 16'h0090, 16'd3, 2, 1'b0);
      // R6 single element, count untouched
      run_xfer(1'b1, 1'b0, 1'b0, 16'h0001, 16'h0020, 16'h0002, 16'h0030, 16'd5, 1, 1'b0);
      // R5 count of one
      run_xfer(1'b0, 1'b0, 1'b1, 16'h4000, 16'h00FF, 16'h5000, 16'h0001, 16'd1, 0, 1'b0);
      test_empty();
      // R4 offset wrap downward, R2 segment carry into bit 19
      run_xfer(1'b1, 1'b1, 1'b1, 16'hFFF0, 16'h0001, 16'hF000, 16'h0002, 16'd2, 0, 1'b0);
      // R10 start while busy ignored
      run_xfer(1'b1, 1'b0, 1'b1, 16'h0200, 16'h0000, 16'h0300, 16'h0000, 16'd5, 1, 1'b1);
      // R8 R4 long waits, destination wrap upward
      run_xfer(1'b1, 1'b0, 1'b1, 16'h0010, 16'h0100, 16'h0020, 16'hFFFC, 16'd3, 3, 1'b0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule